// File: doc/BRIEF.md
# Interrupt Cause and Auto-Mask Unit

This unit gathers single-cycle event pulses from a peripheral into a 31-bit cause word. Bit 31 of the cause word, as software reads it, is a summary bit. The summary bit is high whenever a latched cause is also enabled in the mask register. A level interrupt line is driven from the AND of cause and mask. Software reaches the unit through a simple synchronous register port. Writes take effect at the clock edge. Read data is registered and appears one cycle after the read strobe.

A read of the cause word is the unit's commit point. The rules for clearing the word are set by two bits of the control register:
- `clear-always`: when set, every cause read empties the word.
- `multi-vector`: selects multi-vector signalling, which changes when a read may clear.

When `clear-always` is low, a read empties the cause word only in three cases: the summary bit is high, the mask is empty, or `multi-vector` is off. The same read may also remove the mask bits that are selected in the auto-mask register. This happens when `clear-always` is set, or when the mask is non-empty and the summary bit is high.

Every register access is first classified into one access kind. The kinds are `ACC_IDLE`, `ACC_CAUSE_RD`, `ACC_CAUSE_WR`, `ACC_MSET_WR`, `ACC_MCLR_WR`, `ACC_AMASK_WR`, `ACC_CTL_WR` and `ACC_REG_RD`. One next-state step then applies that kind. The same step always merges in the event pulses that arrived in that cycle.

Top module: `intr_cause_unit`

## Requirements
- R1: After reset, the cause, mask, auto-mask and control registers are zero, `irq_o` is low and `rdata` is zero.
- R2: An event pulse on `evt_i[k]` sets cause bit k at the next edge. This holds even when a clearing cause read or a cause write occurs in the same cycle.
- R3: Writing address 0 (cause) clears every cause bit written as 1 and leaves bits written as 0 unchanged.
- R4: Writing address 1 ORs `wdata` into the mask. Writing address 2 clears the mask bits written as 1. Reading either address returns the mask.
- R5: Reading address 0 returns cause bits 30:0, with bit 31 equal to the OR of (cause AND mask) over bits 30:0. The value is the state in the cycle of the read and appears on `rdata` one cycle after `rd_en`.
- R6: When control bit 0 (clear-always) is 1, every cause read leaves the cause register holding only the events that arrived in the same cycle.
- R7: When control bit 0 is 0, a cause read clears the cause register if the summary bit is 1, or the mask is zero, or control bit 1 (multi-vector) is 0. Otherwise the cause is kept.
- R8: A cause read clears the mask bits set in the auto-mask register (address 3) when control bit 0 is 1, or when the mask is non-zero and the summary bit is 1. The mask never gains bits except through an address 1 write.
- R9: `irq_o` equals the OR of (cause AND mask) over bits 30:0 as held one cycle earlier.
- R10: When `rd_en` and `wr_en` are both high, the read is ignored: `rdata` and the read side effects do not occur. Addresses 5 to 7 read as zero, and writes to them change nothing.
- R11: Addresses 3 (auto-mask) and 4 (control, bits 1:0) read back the last written values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 31 | Event pulses, one per cause bit |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Level interrupt request |

## Verification
A vector table covers every combination of clear-always, empty or non-empty mask, summary bit, and multi-vector mode.
- If the clear rule is wrong, the cause bits are either kept when they should be cleared, or dropped when they should be kept, on the second read.
- If the auto-mask step copies the auto-mask value into the mask instead of clearing bits, the mask readback shows new bits.
- If the auto-mask step runs without a summary, masked sources are silenced.

Directed tests cover three further cases:
- An event that arrives during a clearing read. A design that clears after merging the event loses the event.
- An interrupt line whose latency is off by one cycle.
- A read and a write strobed together. A design that lets the read through clears the cause twice or changes `rdata`.

// File: rtl/intr_cause_pkg.sv
package intr_cause_pkg;
    localparam int ADDR_W = 3;
    localparam int CTL_W  = 2;
    localparam int CTL_CLR_ALL = 0;
    localparam int CTL_MULTIVEC = 1;

    localparam logic [ADDR_W-1:0] A_CAUSE = 3'd0;
    localparam logic [ADDR_W-1:0] A_MSET  = 3'd1;
    localparam logic [ADDR_W-1:0] A_MCLR  = 3'd2;
    localparam logic [ADDR_W-1:0] A_AMASK = 3'd3;
    localparam logic [ADDR_W-1:0] A_CTL   = 3'd4;

    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_CAUSE_RD,
        ACC_CAUSE_WR,
        ACC_MSET_WR,
        ACC_MCLR_WR,
        ACC_AMASK_WR,
        ACC_CTL_WR,
        ACC_REG_RD
    } acc_kind_e;
endpackage

// File: rtl/icu_access_decode.sv
module icu_access_decode
    import intr_cause_pkg::*;
(
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         kind
);
    always_comb begin
        kind = ACC_IDLE;
        if (wr_en) begin
            unique case (addr)
                A_CAUSE: kind = ACC_CAUSE_WR;
                A_MSET:  kind = ACC_MSET_WR;
                A_MCLR:  kind = ACC_MCLR_WR;
                A_AMASK: kind = ACC_AMASK_WR;
                A_CTL:   kind = ACC_CTL_WR;
                default: kind = ACC_IDLE;
            endcase
        end else if (rd_en) begin
            kind = (addr == A_CAUSE) ? ACC_CAUSE_RD : ACC_REG_RD;
        end
    end
endmodule

// File: rtl/icu_clear_policy.sv
module icu_clear_policy
    import intr_cause_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int CAUSE_W = DATA_W - 1
) (
    input  logic [CAUSE_W-1:0] cause_q,
    input  logic [DATA_W-1:0]  mask_q,
    input  logic [CTL_W-1:0]   ctl_q,
    output logic               summary,
    output logic               clr_cause,
    output logic               do_automask
);
    logic mask_empty;

    always_comb begin
        summary    = |(cause_q & mask_q[CAUSE_W-1:0]);
        mask_empty = (mask_q == '0);
        if (ctl_q[CTL_CLR_ALL]) begin
            clr_cause   = 1'b1;
            do_automask = 1'b1;
        end else begin
            clr_cause   = summary || mask_empty || !ctl_q[CTL_MULTIVEC];
            do_automask = !mask_empty && summary;
        end
    end
endmodule

// File: rtl/icu_reg_bank.sv
module icu_reg_bank
    import intr_cause_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int CAUSE_W = DATA_W - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  acc_kind_e          kind,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [CAUSE_W-1:0] evt_i,
    input  logic               summary,
    input  logic               clr_cause,
    input  logic               do_automask,
    output logic [CAUSE_W-1:0] cause_q,
    output logic [DATA_W-1:0]  mask_q,
    output logic [DATA_W-1:0]  amask_q,
    output logic [CTL_W-1:0]   ctl_q,
    output logic [DATA_W-1:0]  rdata,
    output logic               irq_o
);
    logic [CAUSE_W-1:0] cause_n;
    logic [DATA_W-1:0]  mask_n;
    logic [DATA_W-1:0]  amask_n;
    logic [CTL_W-1:0]   ctl_n;
    logic [DATA_W-1:0]  rd_word;
    logic               rd_load;

    always_comb begin
        cause_n = cause_q;
        mask_n  = mask_q;
        amask_n = amask_q;
        ctl_n   = ctl_q;
        unique case (kind)
            ACC_CAUSE_RD: begin
                if (clr_cause)   cause_n = '0;
                if (do_automask) mask_n  = mask_q & ~amask_q;
            end
            ACC_CAUSE_WR: cause_n = cause_q & ~wdata[CAUSE_W-1:0];
            ACC_MSET_WR:  mask_n  = mask_q | wdata;
            ACC_MCLR_WR:  mask_n  = mask_q & ~wdata;
            ACC_AMASK_WR: amask_n = wdata;
            ACC_CTL_WR:   ctl_n   = wdata[CTL_W-1:0];
            default: ;
        endcase
        cause_n = cause_n | evt_i;
    end

    always_comb begin
        rd_load = (kind == ACC_CAUSE_RD) || (kind == ACC_REG_RD);
        unique case (addr)
            A_CAUSE:        rd_word = {summary, cause_q};
            A_MSET, A_MCLR: rd_word = mask_q;
            A_AMASK:        rd_word = amask_q;
            A_CTL:          rd_word = {{(DATA_W-CTL_W){1'b0}}, ctl_q};
            default:        rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= '0;
            mask_q  <= '0;
            amask_q <= '0;
            ctl_q   <= '0;
            rdata   <= '0;
            irq_o   <= 1'b0;
        end else begin
            cause_q <= cause_n;
            mask_q  <= mask_n;
            amask_q <= amask_n;
            ctl_q   <= ctl_n;
            if (rd_load) rdata <= rd_word;
            irq_o   <= |(cause_q & mask_q[CAUSE_W-1:0]);
        end
    end
endmodule

// File: rtl/intr_cause_unit.sv
module intr_cause_unit
    import intr_cause_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int CAUSE_W = DATA_W - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAUSE_W-1:0] evt_i,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic               irq_o
);
    acc_kind_e          kind;
    logic [CAUSE_W-1:0] cause_q;
    logic [DATA_W-1:0]  mask_q;
    logic [DATA_W-1:0]  amask_q;
    logic [CTL_W-1:0]   ctl_q;
    logic               summary;
    logic               clr_cause;
    logic               do_automask;

    icu_access_decode u_dec (
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .kind  (kind)
    );

    icu_clear_policy #(.DATA_W(DATA_W)) u_pol (
        .cause_q     (cause_q),
        .mask_q      (mask_q),
        .ctl_q       (ctl_q),
        .summary     (summary),
        .clr_cause   (clr_cause),
        .do_automask (do_automask)
    );

    icu_reg_bank #(.DATA_W(DATA_W)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .kind        (kind),
        .addr        (addr),
        .wdata       (wdata),
        .evt_i       (evt_i),
        .summary     (summary),
        .clr_cause   (clr_cause),
        .do_automask (do_automask),
        .cause_q     (cause_q),
        .mask_q      (mask_q),
        .amask_q     (amask_q),
        .ctl_q       (ctl_q),
        .rdata       (rdata),
        .irq_o       (irq_o)
    );
endmodule

// File: rtl/intr_cause_unit_chk.sv
module intr_cause_unit_chk
    import intr_cause_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int CAUSE_W = DATA_W - 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [CAUSE_W-1:0] evt_i,
    input logic               wr_en,
    input logic               rd_en,
    input logic [ADDR_W-1:0]  addr,
    input logic [CAUSE_W-1:0] cause_q,
    input logic [DATA_W-1:0]  mask_q,
    input logic [CTL_W-1:0]   ctl_q,
    input logic               summary,
    input logic               irq_o
);
    logic cause_rd;
    assign cause_rd = rd_en && !wr_en && (addr == A_CAUSE);

    assert_evt_latched_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((cause_q & $past(evt_i)) == $past(evt_i)));

    assert_clear_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_rd && ctl_q[CTL_CLR_ALL]) |=> (cause_q == $past(evt_i)));

    assert_keep_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_rd && !ctl_q[CTL_CLR_ALL] && ctl_q[CTL_MULTIVEC] && (mask_q != '0) && !summary)
        |=> (cause_q == ($past(cause_q) | $past(evt_i))));

    assert_mask_no_gain_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (addr == A_MSET)) |=> ((mask_q & ~$past(mask_q)) == '0));

    assert_irq_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|(cause_q & mask_q[CAUSE_W-1:0]))));
endmodule

bind intr_cause_unit intr_cause_unit_chk #(.DATA_W(DATA_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_i   (evt_i),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .cause_q (cause_q),
    .mask_q  (mask_q),
    .ctl_q   (ctl_q),
    .summary (summary),
    .irq_o   (irq_o)
);

// File: tb/intr_cause_unit_tb_top.sv
module intr_cause_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [30:0] evt_i = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    intr_cause_unit dut_i (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
    );

    // ctl: bit0 clear-always, bit1 multi-vector; events 0x5, auto-mask 0x6
    typedef struct packed {
        logic [1:0]  ctl;
        logic [31:0] mask;
        logic [31:0] rd_exp;
        logic [31:0] mask_exp;
        logic [31:0] cause_exp;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VEC [NVEC] = '{
        '{2'b00, 32'h10, 32'h0000_0005, 32'h10, 32'h0},
        '{2'b10, 32'h10, 32'h0000_0005, 32'h10, 32'h5},
        '{2'b10, 32'h00, 32'h0000_0005, 32'h00, 32'h0},
        '{2'b10, 32'h14, 32'h8000_0005, 32'h10, 32'h0},
        '{2'b00, 32'h14, 32'h8000_0005, 32'h10, 32'h0},
        '{2'b11, 32'h12, 32'h0000_0005, 32'h10, 32'h0},
        '{2'b01, 32'h00, 32'h0000_0005, 32'h00, 32'h0},
        '{2'b11, 32'h16, 32'h8000_0005, 32'h10, 32'h0},
        '{2'b10, 32'h12, 32'h0000_0005, 32'h12, 32'h5},
        '{2'b00, 32'h12, 32'h0000_0005, 32'h12, 32'h0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; d = rdata;
    endtask

    task automatic pulse(input logic [30:0] e);
        @(negedge clk); evt_i = e;
        @(negedge clk); evt_i = '0;
    endtask

    task automatic clean();
        wr(3'd4, 32'h0);
        wr(3'd2, 32'hFFFF_FFFF);
        wr(3'd0, 32'hFFFF_FFFF);
        wr(3'd3, 32'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 rdata", rdata, 32'h0);
        check("R1 irq", {31'b0, irq_o}, 32'h0);
        rst_n = 1'b1;
        rd(3'd0, d); check("R1 cause", d, 32'h0);
        rd(3'd1, d); check("R1 mask", d, 32'h0);
        rd(3'd3, d); check("R1 automask", d, 32'h0);
        rd(3'd4, d); check("R1 ctl", d, 32'h0);

        // Table walk: R5 R6 R7 R8
        for (int i = 0; i < NVEC; i++) begin
            clean();
            wr(3'd3, 32'h6);
            wr(3'd1, VEC[i].mask);
            wr(3'd4, {30'b0, VEC[i].ctl});
            pulse(31'h5);
            rd(3'd0, d); check($sformatf("R5 vec%0d read", i), d, VEC[i].rd_exp);
            rd(3'd1, d); check($sformatf("R8 vec%0d mask", i), d, VEC[i].mask_exp);
            rd(3'd0, d); check($sformatf("R7 R6 vec%0d cause", i), {1'b0, d[30:0]}, VEC[i].cause_exp);
        end

        // R2: event during clearing read survives
        clean();
        wr(3'd4, 32'h1);
        pulse(31'h1);
        @(negedge clk); rd_en = 1'b1; addr = 3'd0; evt_i = 31'h8;
        @(negedge clk); rd_en = 1'b0; evt_i = '0;
        check("R2 read during event", rdata, 32'h1);
        rd(3'd0, d); check("R2 event kept", d, 32'h8);

        // R3: write-one-to-clear
        clean();
        pulse(31'hF);
        wr(3'd0, 32'h5);
        wr(3'd4, 32'h1);
        rd(3'd0, d); check("R3 w1c", d, 32'hA);

        // R4: mask set/clear
        clean();
        wr(3'd1, 32'h3); wr(3'd1, 32'h4);
        rd(3'd1, d); check("R4 set or", d, 32'h7);
        wr(3'd2, 32'h2);
        rd(3'd2, d); check("R4 clear", d, 32'h5);

        // R9: irq latency
        clean();
        wr(3'd1, 32'h1);
        @(negedge clk); evt_i = 31'h1;
        @(negedge clk); evt_i = '0;
        check("R9 irq not yet", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        check("R9 irq raised", {31'b0, irq_o}, 32'h1);

        // R10: simultaneous read+write, unmapped addresses
        clean();
        pulse(31'h3);
        rd(3'd3, d);
        @(negedge clk); wr_en = 1'b1; rd_en = 1'b1; addr = 3'd0; wdata = 32'h1;
        @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
        check("R10 rdata held", rdata, 32'h0);
        wr(3'd6, 32'hFFFF_FFFF);
        rd(3'd6, d); check("R10 unmapped", d, 32'h0);
        rd(3'd0, d); check("R10 cause after", d, 32'h2);

        // R11: readback
        wr(3'd3, 32'hA5A5_0000);
        rd(3'd3, d); check("R11 automask", d, 32'hA5A5_0000);
        wr(3'd4, 32'hFFFF_FFFE);
        rd(3'd4, d); check("R11 ctl", d, 32'h2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule